// File: doc/BRIEF.md
# Delayed Read Target Controller

This block serves reads that a bus master issues through a target port toward an internal memory-mapped bus, using split completion. The first read beat of a transaction is answered with retry while the block records its address and command and fetches a run of words over a simple burst request/response bus into a local word store. The master keeps repeating the read. Every repeat gets retry until the fetch has finished. Once the words are buffered, only a beat with the recorded address and command is accepted and served from the store, one word per beat.

The master side is an abstract per-beat interface. Each beat carries a first-beat flag, a last-beat flag, an address and a 4-bit command. Each beat gets exactly one registered response in the next cycle. The number of words fetched depends on the command and a cache-line setting, and is cut short at an aligned block boundary. Buffered data that is never collected is dropped by a watchdog. A bus error during the fetch is reported through status bits and interrupts, and the repeat is then refused with target abort.

Top module: `dly_rd_tgt`

## Requirements
- R1: While `cfg_direct_i` is 1, request beats get no response (`rsp_valid_o` stays 0), nothing is recorded and no internal request is raised.
- R2: With no access pending, a first beat carrying command 4'h6, 4'hE or 4'hC gets RETRY in the next cycle. The block then holds `ib_req_o` high with a word-aligned `ib_addr_o` and a stable `ib_len_o` until `ib_ack_i` is sampled. Any other command gets RETRY and nothing is recorded. Response codes on `rsp_kind_o` are 0 DATA, 1 RETRY, 2 DISCONNECT and 3 ABORT.
- R3: While the fetch is running, every beat gets RETRY, including an exact repeat of the recorded access.
- R4: After the fetch, a first beat whose address or command differs from the recorded pair gets RETRY. A matching first beat gets DATA carrying buffered word 0, and each following non-first beat gets the next word in order. Every enabled beat gets exactly one response in the following cycle.
- R5: Fetch length is 1 word for 4'h6 and 16 for 4'hC. For 4'hE it is `cls_words_i` when `cls_valid_i` is 1 and the value lies in 1..16, and 16 otherwise.
- R6: The fetch never crosses a 64-byte aligned block: its length is the smaller of the R5 value and 16 minus address bits [5:2].
- R7: A beat asking for a word beyond the buffered count gets DISCONNECT and ends the access. A DATA beat carrying the last-beat flag also ends it. After either, a new read is recorded.
- R8: A matching repeat is accepted up to and including the 32768th cycle after the fetch completes. Without one, the data is dropped, status bit 0 is set and `irq_local_o` rises unless `irq_mask_i[0]` is 1. A later repeat is treated as a new read.
- R9: An error flagged on any fetch beat sets status bit 1 (local) and bit 2 (host) when the last beat arrives. `irq_local_o` follows bit 1 unless `irq_mask_i[1]` is set, and `irq_host_o` follows bit 2 unless `irq_mask_i[2]` is set. The matching repeat gets ABORT and ends the access.
- R10: Status bits are write-1-to-clear through `sts_clr_i` (same bit positions). A set in the same cycle as a clear leaves the bit set.
- R11: After reset no response or internal request is active and all status bits and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_direct_i | input | 1 | 1 disables the split-read path |
| cls_valid_i | input | 1 | Cache-line setting is valid |
| cls_words_i | input | 5 | Cache-line size in words |
| req_valid_i | input | 1 | Request beat present |
| req_first_i | input | 1 | Beat is the first of a transaction |
| req_last_i | input | 1 | Beat is the last of a transaction |
| req_addr_i | input | 32 | Beat byte address |
| req_cmd_i | input | 4 | Bus command |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 2 | 0 DATA, 1 RETRY, 2 DISCONNECT, 3 ABORT |
| rsp_data_o | output | 32 | Read word for DATA |
| ib_req_o | output | 1 | Internal burst request |
| ib_ack_i | input | 1 | Internal request accepted |
| ib_addr_o | output | 32 | Internal burst start address |
| ib_len_o | output | 5 | Internal burst length in words |
| ib_rvalid_i | input | 1 | Internal read beat |
| ib_rdata_i | input | 32 | Internal read word |
| ib_rerr_i | input | 1 | Internal beat carries a bus error |
| irq_mask_i | input | 3 | Interrupt masks per status bit |
| sts_clr_i | input | 3 | Write-1-to-clear strobes per status bit |
| sts_o | output | 3 | Status: 0 discard, 1 local error, 2 host error |
| irq_local_o | output | 1 | Local interrupt |
| irq_host_o | output | 1 | Host interrupt |

## Verification
Two events can fall in the same cycle. The first is the arrival of the matching repeat and the expiry of the discard watchdog. The bench places the repeat exactly on the last allowed cycle and requires DATA, then lets a second fetch expire and requires the discard flag and a fresh recording. The second is a status set and its clear strobe: the bench drives the clear on exactly the expiry cycle and requires the flag to stay set. A behavioural model built on queues predicts every response, internal request and status bit and is compared with the design on each clock.

// File: rtl/dly_rd_pkg.sv
package dly_rd_pkg;
  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_DISC  = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READY,
    ST_ERR,
    ST_SERVE
  } dr_state_e;

  localparam logic [3:0] CMD_MR  = 4'h6;
  localparam logic [3:0] CMD_MRL = 4'hE;
  localparam logic [3:0] CMD_MRM = 4'hC;

  function automatic logic is_read_cmd(logic [3:0] cmd);
    return (cmd == CMD_MR) || (cmd == CMD_MRL) || (cmd == CMD_MRM);
  endfunction
endpackage

// File: rtl/dly_rd_len.sv
module dly_rd_len
  import dly_rd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [3:0]       cmd_i,
  input  logic             cls_valid_i,
  input  logic [LEN_W-1:0] cls_words_i,
  input  logic [PTR_W-1:0] addr_word_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] base, room;
  logic             cls_ok;

  assign cls_ok = cls_valid_i && (cls_words_i != '0) && (cls_words_i <= LEN_W'(DEPTH));

  always_comb begin
    base = LEN_W'(DEPTH);
    if (cmd_i == CMD_MR)                 base = LEN_W'(1);
    else if (cmd_i == CMD_MRL && cls_ok) base = cls_words_i;
  end

  // words left before the aligned block ends
  assign room  = LEN_W'(DEPTH) - LEN_W'(addr_word_i);
  assign len_o = (base < room) ? base : room;
endmodule

// File: rtl/dly_rd_fifo.sv
module dly_rd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_ptr_i];
endmodule

// File: rtl/dly_rd_timer.sv
module dly_rd_timer #(
  parameter int LIMIT = 32768,
  localparam int CW = $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  assign expire_o = run_i && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dly_rd_tgt.sv
module dly_rd_tgt
  import dly_rd_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 32768,
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_direct_i,
  input  logic             cls_valid_i,
  input  logic [LEN_W-1:0] cls_words_i,
  input  logic             req_valid_i,
  input  logic             req_first_i,
  input  logic             req_last_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [3:0]       req_cmd_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_kind_o,
  output logic [DW-1:0]    rsp_data_o,
  output logic             ib_req_o,
  input  logic             ib_ack_i,
  output logic [AW-1:0]    ib_addr_o,
  output logic [LEN_W-1:0] ib_len_o,
  input  logic             ib_rvalid_i,
  input  logic [DW-1:0]    ib_rdata_i,
  input  logic             ib_rerr_i,
  input  logic [2:0]       irq_mask_i,
  input  logic [2:0]       sts_clr_i,
  output logic [2:0]       sts_o,
  output logic             irq_local_o,
  output logic             irq_host_o
);
  dr_state_e        state, st_d;
  logic [AW-1:0]    lat_addr;
  logic [3:0]       lat_cmd;
  logic [LEN_W-1:0] lat_len, calc_len, wr_cnt, rd_ptr;
  logic             err_seen, ib_req;
  logic             hit, same, fetch_done, tmr_expire;
  logic             latch, serve, drop, set_err;
  rsp_kind_e        kind_d;
  logic [DW-1:0]    data_d, rd_data;
  logic [PTR_W-1:0] rd_idx;
  logic [2:0]       sts;

  assign hit        = req_valid_i && !cfg_direct_i;
  assign same       = (req_addr_i == lat_addr) && (req_cmd_i == lat_cmd);
  assign fetch_done = (state == ST_FETCH) && ib_rvalid_i && (wr_cnt == lat_len - LEN_W'(1));
  assign rd_idx     = (state == ST_SERVE) ? rd_ptr[PTR_W-1:0] : '0;

  dly_rd_len #(.DEPTH(DEPTH)) u_len (
    .cmd_i       (req_cmd_i),
    .cls_valid_i (cls_valid_i),
    .cls_words_i (cls_words_i),
    .addr_word_i (req_addr_i[PTR_W+1:2]),
    .len_o       (calc_len)
  );

  dly_rd_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
    .clk_i     (clk_i),
    .wr_en_i   ((state == ST_FETCH) && ib_rvalid_i),
    .wr_ptr_i  (wr_cnt[PTR_W-1:0]),
    .wr_data_i (ib_rdata_i),
    .rd_ptr_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  dly_rd_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state == ST_READY),
    .expire_o (tmr_expire)
  );

  always_comb begin
    st_d    = state;
    kind_d  = RSP_RETRY;
    data_d  = '0;
    latch   = 1'b0;
    serve   = 1'b0;
    drop    = 1'b0;
    set_err = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hit && req_first_i && is_read_cmd(req_cmd_i)) begin
          latch = 1'b1;
          st_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetch_done) begin
          set_err = err_seen || ib_rerr_i;
          st_d    = set_err ? ST_ERR : ST_READY;
        end
      end
      ST_READY: begin
        // a repeat in the expiry cycle still wins
        if (hit && req_first_i && same) begin
          kind_d = RSP_DATA;
          data_d = rd_data;
          serve  = 1'b1;
          st_d   = req_last_i ? ST_IDLE : ST_SERVE;
        end else if (tmr_expire) begin
          drop = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_ERR: begin
        if (hit && req_first_i && same) begin
          kind_d = RSP_ABORT;
          st_d   = ST_IDLE;
        end
      end
      ST_SERVE: begin
        if (hit && !req_first_i) begin
          if (rd_ptr < lat_len) begin
            kind_d = RSP_DATA;
            data_d = rd_data;
            serve  = 1'b1;
            if (req_last_i) st_d = ST_IDLE;
          end else begin
            kind_d = RSP_DISC;
            st_d   = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      lat_addr    <= '0;
      lat_cmd     <= '0;
      lat_len     <= '0;
      wr_cnt      <= '0;
      rd_ptr      <= '0;
      err_seen    <= 1'b0;
      ib_req      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= RSP_DATA;
      rsp_data_o  <= '0;
      sts         <= '0;
    end else begin
      state       <= st_d;
      rsp_valid_o <= hit;
      rsp_kind_o  <= kind_d;
      rsp_data_o  <= data_d;
      sts         <= (sts & ~sts_clr_i) | {set_err, set_err, drop};
      if (ib_req && ib_ack_i) ib_req <= 1'b0;
      if (latch) begin
        lat_addr <= req_addr_i;
        lat_cmd  <= req_cmd_i;
        lat_len  <= calc_len;
        wr_cnt   <= '0;
        err_seen <= 1'b0;
        ib_req   <= 1'b1;
      end else if (state == ST_FETCH && ib_rvalid_i) begin
        wr_cnt <= wr_cnt + LEN_W'(1);
        if (ib_rerr_i) err_seen <= 1'b1;
      end
      if (serve) rd_ptr <= (state == ST_READY) ? LEN_W'(1) : rd_ptr + LEN_W'(1);
    end
  end

  assign ib_req_o    = ib_req;
  assign ib_addr_o   = {lat_addr[AW-1:2], 2'b00};
  assign ib_len_o    = lat_len;
  assign sts_o       = sts;
  assign irq_local_o = |(sts[1:0] & ~irq_mask_i[1:0]);
  assign irq_host_o  = sts[2] && !irq_mask_i[2];
endmodule

// File: rtl/dly_rd_tgt_chk.sv
module dly_rd_tgt_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_direct_i,
  input logic             req_valid_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_kind_o,
  input logic             ib_req_o,
  input logic             ib_ack_i,
  input logic [AW-1:0]    ib_addr_o,
  input logic [LEN_W-1:0] ib_len_o,
  input logic [2:0]       sts_clr_i,
  input logic [2:0]       sts_o
);
  assert_no_rsp_direct_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_direct_i) |=> !rsp_valid_o);

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_req_o && !ib_ack_i) |=> (ib_req_o && $stable(ib_addr_o) && $stable(ib_len_o)));

  assert_retry_in_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cfg_direct_i && ib_req_o) |=> (rsp_kind_o == 2'd1));

  assert_one_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cfg_direct_i) |=> rsp_valid_o);

  assert_idle_no_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_len_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_req_o |-> (ib_len_o != '0 && ib_len_o <= LEN_W'(DEPTH)));

  assert_no_cross_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_req_o |-> ((LEN_W + 1)'(ib_addr_o[PTR_W+1:2]) + (LEN_W + 1)'(ib_len_o) <= (LEN_W + 1)'(DEPTH)));

  assert_err_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[1]) |-> sts_o[2]);

  assert_sticky_discard_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[0] && !sts_clr_i[0]) |=> sts_o[0]);
endmodule

bind dly_rd_tgt dly_rd_tgt_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_direct_i (cfg_direct_i),
  .req_valid_i  (req_valid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_kind_o   (rsp_kind_o),
  .ib_req_o     (ib_req_o),
  .ib_ack_i     (ib_ack_i),
  .ib_addr_o    (ib_addr_o),
  .ib_len_o     (ib_len_o),
  .sts_clr_i    (sts_clr_i),
  .sts_o        (sts_o)
);

// File: tb/dly_rd_tgt_tb.sv
module dly_rd_tgt_tb_top;
  localparam int T = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_direct = 1'b0, cls_valid = 1'b1;
  logic [4:0]  cls_words = 5'd8;
  logic        req_valid = 1'b0, req_first = 1'b0, req_last = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_data;
  logic        ib_req, ib_ack = 1'b0, ib_rvalid = 1'b0, ib_rerr = 1'b0;
  logic [31:0] ib_addr, ib_rdata = '0;
  logic [4:0]  ib_len;
  logic [2:0]  irq_mask = '0, sts_clr = '0, sts;
  logic        irq_local, irq_host;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  dly_rd_tgt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_direct_i(cfg_direct),
    .cls_valid_i(cls_valid), .cls_words_i(cls_words),
    .req_valid_i(req_valid), .req_first_i(req_first), .req_last_i(req_last),
    .req_addr_i(req_addr), .req_cmd_i(req_cmd),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_data_o(rsp_data),
    .ib_req_o(ib_req), .ib_ack_i(ib_ack), .ib_addr_o(ib_addr), .ib_len_o(ib_len),
    .ib_rvalid_i(ib_rvalid), .ib_rdata_i(ib_rdata), .ib_rerr_i(ib_rerr),
    .irq_mask_i(irq_mask), .sts_clr_i(sts_clr), .sts_o(sts),
    .irq_local_o(irq_local), .irq_host_o(irq_host)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  function automatic int plen(logic [3:0] c, logic [31:0] a);
    int b = 16;
    int room = 16 - int'(a[5:2]);
    if (c == 4'h6) b = 1;
    else if (c == 4'hE && cls_valid && cls_words >= 1 && cls_words <= 16) b = int'(cls_words);
    return (b < room) ? b : room;
  endfunction

  // behavioural reference
  int          m_st, m_len, m_rd, m_tmr;
  logic [31:0] m_addr;
  logic [3:0]  m_cmd;
  logic [31:0] m_q[$];
  bit          m_err, e_ibreq, e_v;
  int          e_k;
  logic [31:0] e_d;
  logic [2:0]  e_sts;

  always @(posedge clk) begin : mdl
    bit hit, same, rd;
    int nk;
    logic [31:0] nd;
    logic [2:0] st_set;
    if (!rst_n) begin
      m_st = 0; e_ibreq = 0; e_v = 0; e_k = 0; e_d = 0; e_sts = 0; m_q.delete();
    end else begin
      hit = req_valid && !cfg_direct;
      same = (req_addr == m_addr) && (req_cmd == m_cmd);
      rd = (req_cmd == 4'h6) || (req_cmd == 4'hE) || (req_cmd == 4'hC);
      nk = 1; nd = 0; st_set = 0;
      if (e_ibreq && ib_ack) e_ibreq = 0;
      case (m_st)
        0: if (hit && req_first && rd) begin
             m_addr = req_addr; m_cmd = req_cmd; m_len = plen(req_cmd, req_addr);
             m_q.delete(); m_err = 0; e_ibreq = 1; m_st = 1;
           end
        1: if (ib_rvalid) begin
             m_q.push_back(ib_rdata);
             if (ib_rerr) m_err = 1;
             if (m_q.size() == m_len) begin
               if (m_err) begin m_st = 3; st_set = 3'b110; end
               else begin m_st = 2; m_tmr = 0; end
             end
           end
        2: if (hit && req_first && same) begin
             nk = 0; nd = m_q[0]; m_rd = 1; m_st = req_last ? 0 : 4;
           end else if (m_tmr == T - 1) begin
             m_st = 0; st_set = 3'b001;
           end else m_tmr++;
        3: if (hit && req_first && same) begin nk = 3; m_st = 0; end
        4: if (hit && !req_first) begin
             if (m_rd < m_len) begin
               nk = 0; nd = m_q[m_rd]; m_rd++;
               if (req_last) m_st = 0;
             end else begin nk = 2; m_st = 0; end
           end
        default: m_st = 0;
      endcase
      e_v = hit; e_k = nk; e_d = nd;
      e_sts = (e_sts & ~sts_clr) | st_set;
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    #2ns;
    if (rst_n && !done) begin
      chk("R4 rsp_valid", rsp_valid, e_v);
      if (e_v) begin
        chk("R4 rsp_kind", rsp_kind, e_k);
        if (e_k == 0) chk("R4 rsp_data", rsp_data, e_d);
      end
      chk("R2 ib_req", ib_req, e_ibreq);
      if (e_ibreq) begin
        chk("R2 ib_addr", ib_addr, {m_addr[31:2], 2'b00});
        chk("R5 ib_len", ib_len, m_len);
      end
      chk("R10 sts", sts, e_sts);
      chk("R9 irq_local", irq_local, |(e_sts[1:0] & ~irq_mask[1:0]));
      chk("R9 irq_host", irq_host, e_sts[2] & ~irq_mask[2]);
    end
  end

  task automatic beat(bit f, bit l, logic [31:0] a, logic [3:0] c);
    req_valid = 1; req_first = f; req_last = l; req_addr = a; req_cmd = c;
    @(negedge clk);
    req_valid = 0; req_first = 0; req_last = 0;
  endtask

  task automatic read_burst(logic [31:0] a, logic [3:0] c, int n);
    beat(1, n == 1, a, c);
    for (int i = 1; i < n; i++) beat(0, i == n - 1, a + 32'(4 * i), c);
  endtask

  task automatic ib_serve(int err_at);
    int n;
    while (!ib_req) @(negedge clk);
    n = int'(ib_len);
    ib_ack = 1; @(negedge clk); ib_ack = 0;
    for (int i = 0; i < n; i++) begin
      ib_rvalid = 1; ib_rdata = pat(ib_addr + 32'(4 * i)); ib_rerr = (i == err_at);
      @(negedge clk);
    end
    ib_rvalid = 0; ib_rerr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 ib_req", ib_req, 0);
    chk("R11 sts", sts, 0);
    chk("R11 irq", {irq_local, irq_host}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: path disabled
    cfg_direct = 1;
    beat(1, 1, 32'h100, 4'h6);
    chk("R1 no rsp", rsp_valid, 0);
    chk("R1 no ib_req", ib_req, 0);
    cfg_direct = 0;

    // R2: unsupported command
    beat(1, 1, 32'h100, 4'h7);
    chk("R2 other cmd retry", rsp_kind, 1);
    chk("R2 other cmd no fetch", ib_req, 0);

    // R2, R3, R4, R5: single word read
    beat(1, 1, 32'h104, 4'h6);
    chk("R2 first retry", rsp_kind, 1);
    chk("R5 mr len", ib_len, 1);
    chk("R2 aligned addr", ib_addr, 32'h104);
    beat(1, 1, 32'h104, 4'h6);
    chk("R3 repeat during fetch", rsp_kind, 1);
    ib_serve(-1);
    beat(1, 1, 32'h108, 4'h6);
    chk("R4 addr mismatch", rsp_kind, 1);
    beat(1, 1, 32'h104, 4'hC);
    chk("R4 cmd mismatch", rsp_kind, 1);
    beat(1, 1, 32'h104, 4'h6);
    chk("R4 match data", {rsp_kind, rsp_data}, {2'd0, pat(32'h104)});

    // R5, R7: cache-line read with overrun
    cls_valid = 1; cls_words = 5'd8;
    beat(1, 1, 32'h200, 4'hE);
    chk("R5 mrl len", ib_len, 8);
    ib_serve(-1);
    read_burst(32'h200, 4'hE, 9);
    chk("R7 disconnect", rsp_kind, 2);

    // R6: boundary cut, R7: last flag ends
    beat(1, 1, 32'h3E0, 4'hC);
    chk("R7 new read latched", ib_req, 1);
    chk("R6 boundary len", ib_len, 8);
    ib_serve(-1);
    read_burst(32'h3E0, 4'hC, 2);
    chk("R7 last data", {rsp_kind, rsp_data}, {2'd0, pat(32'h3E4)});

    // R5: invalid cache-line setting
    cls_valid = 0;
    beat(1, 1, 32'h400, 4'hE);
    chk("R5 invalid cls len", ib_len, 16);
    ib_serve(-1);
    read_burst(32'h400, 4'hE, 16);
    chk("R5 full read end", {rsp_kind, rsp_data}, {2'd0, pat(32'h43C)});
    cls_valid = 1;

    // R9: bus error
    cls_words = 5'd4;
    beat(1, 1, 32'h500, 4'hE);
    ib_serve(1);
    chk("R9 status", sts, 3'b110);
    chk("R9 irqs", {irq_local, irq_host}, 2'b11);
    beat(1, 1, 32'h504, 4'hE);
    chk("R9 mismatch retry", rsp_kind, 1);
    beat(1, 1, 32'h500, 4'hE);
    chk("R9 abort", rsp_kind, 3);
    irq_mask = 3'b110; #1ns;
    chk("R9 masked", {irq_local, irq_host}, 2'b00);
    sts_clr = 3'b110; @(negedge clk); sts_clr = 0;
    chk("R10 w1c", sts, 0);
    irq_mask = 0;

    // R8: repeat on the last allowed cycle
    beat(1, 1, 32'h600, 4'h6);
    ib_serve(-1);
    repeat (T - 1) @(negedge clk);
    beat(1, 1, 32'h600, 4'h6);
    chk("R8 last cycle accepted", {rsp_kind, rsp_data}, {2'd0, pat(32'h600)});

    // R8 expiry, R10 set beats clear in same cycle
    beat(1, 1, 32'h700, 4'h6);
    ib_serve(-1);
    repeat (T - 1) @(negedge clk);
    sts_clr = 3'b001; @(negedge clk); sts_clr = 0;
    chk("R10 set wins", sts[0], 1);
    chk("R8 discard irq", irq_local, 1);
    irq_mask = 3'b001; #1ns;
    chk("R8 discard masked", irq_local, 0);
    irq_mask = 0;
    beat(1, 1, 32'h700, 4'h6);
    chk("R8 dropped retry", rsp_kind, 1);
    chk("R8 refetch", ib_req, 1);
    ib_serve(-1);
    beat(1, 1, 32'h700, 4'h6);
    chk("R8 refetched data", {rsp_kind, rsp_data}, {2'd0, pat(32'h700)});
    sts_clr = 3'b001; @(negedge clk); sts_clr = 0;
    chk("R10 cleared", sts, 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule